// File: doc/BRIEF.md
# Segmented Descriptor Ring Consumer

This block reads 16-byte work entries from a circular ring in memory. The ring is made of segments joined by link entries. It groups the entries into transfer descriptors. Entry ownership is decided by a cycle bit carried in each entry. A consumer-side cycle value is compared against that bit. A mismatch means the producer has not yet written that slot. There are no head or tail indices.

A link entry sends the fetch to another segment and can invert the expected cycle value. Chained data entries are collected into one descriptor. The descriptor is released only after its final entry (the one with the chain bit clear) has been read.

Software loads the dequeue pointer and cycle state through a simple write port, and both are always visible on outputs. A one-cycle `start_i` pulse runs one dequeue operation. The block issues single-beat 128-bit reads through a request/response port. It stores up to `DEPTH` data entries internally. If the descriptor completes, it streams those entries out with their addresses and a last flag. The operation then ends with a one-cycle done pulse and a status code.

Top module: `trb_ring_consumer`

## Requirements
- R1: After reset, the dequeue pointer is 0, the cycle state is 0, and busy, done, memory request and stream valid are all low.
- R2: Software writes are accepted only when the block is idle. A write in the same cycle as `start_i` takes effect, and fetching begins at the written address. Writes made while busy have no effect. The low four bits of a written pointer are forced to zero.
- R3: Each fetch is a single read of a 16-byte-aligned address equal to the dequeue pointer. The address is held until `mem_ready_i` accepts it. The entry fields are:
  - cycle: bit 96
  - toggle: bit 97
  - chain: bit 100
  - type: bits 111:106, where the value 6 marks a link
  - segment pointer: bits AW-1:4, with bits 3:0 taken as zero.
- R4: An entry whose cycle bit differs from the cycle state is not consumed. If no data entry has been gathered yet, the operation ends with status EMPTY (1). Any link traversals made so far are kept, and the pointer stays on the unowned entry.
- R5: Owned data entries with chain set are gathered, and the pointer advances by 16 per data entry. The first owned data entry with chain clear completes the descriptor.
- R6: A link entry is never emitted. It loads the pointer with its segment pointer. It inverts the cycle state only when its toggle bit is set, and only once it has been consumed with a matching cycle bit.
- R7: Entries of a complete descriptor leave on the stream in fetch order, each with its address. `td_last_o` is set only on the final entry. A stalled beat holds its data and address. No fetch is made while the stream is active.
- R8: If an unowned entry is met after at least one data entry was gathered, the status is INCOMPLETE (2). Nothing is emitted, and the pointer and cycle state return to their values at the start of the operation.
- R9: A descriptor of exactly `DEPTH` entries is emitted normally. A descriptor with more than `DEPTH` entries gives status TOO_LONG (4), emits nothing, and restores the pointer and cycle state.
- R10: If advancing the pointer by 16 past a data entry would overflow the address width, the status is BAD_PTR (3). Nothing is emitted, and the pointer and cycle state are restored.
- R11: Each operation ends with exactly one single-cycle `done_o` while idle, with `status_o` valid. A completed descriptor reports OK (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run one dequeue operation (taken when idle) |
| ptr_wr_i | input | 1 | Load dequeue pointer |
| ptr_wdata_i | input | AW | Pointer value to load |
| cyc_wr_i | input | 1 | Load cycle state |
| cyc_wdata_i | input | 1 | Cycle value to load |
| deq_ptr_o | output | AW | Current dequeue pointer |
| ccs_o | output | 1 | Current consumer cycle state |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| status_o | output | 3 | Result of last operation: 0 OK, 1 EMPTY, 2 INCOMPLETE, 3 BAD_PTR, 4 TOO_LONG |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read address |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 128 | Read data |
| td_valid_o | output | 1 | Descriptor entry valid |
| td_ready_i | input | 1 | Sink accepts entry |
| td_data_o | output | 128 | Entry contents |
| td_addr_o | output | AW | Entry address |
| td_last_o | output | 1 | Final entry of descriptor |

## Verification
A software write can land in the same cycle as the start pulse. It can also land in the middle of a running fetch, in the same cycle as a link redirect or a pointer increment. The bench provokes the first case by raising `ptr_wr_i` together with `start_i`. It expects the emitted addresses to begin at the written value. It provokes the second by pulsing both write strobes a few cycles into an eight-entry descriptor. Both cases are judged at the ports. The final pointer must equal the one the ring walk alone predicts, and the cycle state must be unchanged.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int TRB_W     = 128;
  localparam int CYC_BIT   = 96;
  localparam int TOG_BIT   = 97;
  localparam int CHAIN_BIT = 100;
  localparam int TYPE_LO   = 106;
  localparam int TYPE_W    = 6;
  localparam logic [TYPE_W-1:0] LINK_TYPE = 6'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DRAIN} state_e;

  typedef enum logic [2:0] {
    STS_OK         = 3'd0,
    STS_EMPTY      = 3'd1,
    STS_INCOMPLETE = 3'd2,
    STS_BAD_PTR    = 3'd3,
    STS_TOO_LONG   = 3'd4
  } status_e;
endpackage

// File: rtl/trc_decode.sv
module trc_decode
  import trc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [TRB_W-1:0] trb_i,
  output logic             cyc_o,
  output logic             tog_o,
  output logic             chain_o,
  output logic             link_o,
  output logic [AW-1:0]    seg_o
);
  logic unused_bits;
  assign unused_bits = ^trb_i;

  assign cyc_o   = trb_i[CYC_BIT];
  assign tog_o   = trb_i[TOG_BIT];
  assign chain_o = trb_i[CHAIN_BIT];
  assign link_o  = (trb_i[TYPE_LO +: TYPE_W] == LINK_TYPE);
  assign seg_o   = {trb_i[AW-1:4], 4'b0000};
endmodule

// File: rtl/trc_ptr_inc.sv
module trc_ptr_inc #(
  parameter int AW   = 32,
  parameter int STEP = 16
) (
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] nxt_o,
  output logic          ovf_o
);
  logic [AW:0] sum;
  assign sum   = {1'b0, ptr_i} + (AW+1)'(STEP);
  assign nxt_o = sum[AW-1:0];
  assign ovf_o = sum[AW];
endmodule

// File: rtl/trc_td_buf.sv
module trc_td_buf #(
  parameter int AW    = 32,
  parameter int DW    = 128,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          commit_i,
  input  logic          flush_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] data_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          drained_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] data_q [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] rd_q;
  logic          drain_q;
  logic [IW-1:0] wr_idx;

  assign wr_idx = IW'(cnt_q);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        addr_q[g] <= '0;
      end else if (push_i && wr_idx == IW'(g)) begin
        data_q[g] <= push_data_i;
        addr_q[g] <= push_addr_i;
      end
    end
  end

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign valid_o   = drain_q;
  assign data_o    = data_q[rd_q];
  assign addr_o    = addr_q[rd_q];
  assign last_o    = drain_q && ({1'b0, rd_q} == (CW+1)'(cnt_q) - (CW+1)'(1));
  assign drained_o = drain_q && ready_i && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rd_q    <= '0;
      drain_q <= 1'b0;
    end else if (flush_i) begin
      cnt_q   <= '0;
      rd_q    <= '0;
      drain_q <= 1'b0;
    end else begin
      if (push_i) cnt_q <= cnt_q + CW'(1);
      if (commit_i) begin
        drain_q <= 1'b1;
        rd_q    <= '0;
      end else if (drain_q && ready_i) begin
        if (last_o) begin
          drain_q <= 1'b0;
          cnt_q   <= '0;
          rd_q    <= '0;
        end else begin
          rd_q <= rd_q + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/trb_ring_consumer.sv
module trb_ring_consumer
  import trc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ptr_wr_i,
  input  logic [AW-1:0] ptr_wdata_i,
  input  logic          cyc_wr_i,
  input  logic          cyc_wdata_i,
  output logic [AW-1:0] deq_ptr_o,
  output logic          ccs_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    status_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  input  logic [127:0]  mem_rdata_i,
  output logic          td_valid_o,
  input  logic          td_ready_i,
  output logic [127:0]  td_data_o,
  output logic [AW-1:0] td_addr_o,
  output logic          td_last_o
);
  state_e        state_q;
  status_e       status_q;
  logic [AW-1:0] ptr_q, sv_ptr_q;
  logic          ccs_q, sv_ccs_q, done_q;

  logic          d_cyc, d_tog, d_chain, d_link;
  logic [AW-1:0] d_seg, inc_ptr;
  logic          inc_ovf;
  logic          b_empty, b_full, b_drained;
  logic          resp, owned, push, commit, flush;
  logic [AW-1:0] ptr_ld;
  logic          unused_wlo;

  assign unused_wlo = ^ptr_wdata_i[3:0];
  assign ptr_ld     = {ptr_wdata_i[AW-1:4], 4'b0000};

  trc_decode #(.AW(AW)) u_dec (
    .trb_i  (mem_rdata_i),
    .cyc_o  (d_cyc),
    .tog_o  (d_tog),
    .chain_o(d_chain),
    .link_o (d_link),
    .seg_o  (d_seg)
  );

  trc_ptr_inc #(.AW(AW), .STEP(16)) u_inc (
    .ptr_i(ptr_q),
    .nxt_o(inc_ptr),
    .ovf_o(inc_ovf)
  );

  assign resp   = (state_q == ST_WAIT) && mem_rvalid_i;
  assign owned  = (d_cyc == ccs_q);
  assign push   = resp && owned && !d_link && !inc_ovf && !b_full;
  assign commit = push && !d_chain;
  assign flush  = resp && (!owned || (!d_link && (inc_ovf || b_full)));

  trc_td_buf #(.AW(AW), .DW(TRB_W), .DEPTH(DEPTH)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_data_i(mem_rdata_i),
    .push_addr_i(ptr_q),
    .commit_i   (commit),
    .flush_i    (flush),
    .empty_o    (b_empty),
    .full_o     (b_full),
    .valid_o    (td_valid_o),
    .ready_i    (td_ready_i),
    .data_o     (td_data_o),
    .addr_o     (td_addr_o),
    .last_o     (td_last_o),
    .drained_o  (b_drained)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      status_q <= STS_OK;
      ptr_q    <= '0;
      ccs_q    <= 1'b0;
      sv_ptr_q <= '0;
      sv_ccs_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ptr_wr_i) ptr_q <= ptr_ld;
          if (cyc_wr_i) ccs_q <= cyc_wdata_i;
          if (start_i) begin
            sv_ptr_q <= ptr_wr_i ? ptr_ld : ptr_q;
            sv_ccs_q <= cyc_wr_i ? cyc_wdata_i : ccs_q;
            state_q  <= ST_REQ;
          end
        end
        ST_REQ: if (mem_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          if (!owned) begin
            // empty keeps link walks; partial descriptor rewinds
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            status_q <= b_empty ? STS_EMPTY : STS_INCOMPLETE;
            if (!b_empty) begin
              ptr_q <= sv_ptr_q;
              ccs_q <= sv_ccs_q;
            end
          end else if (d_link) begin
            ptr_q   <= d_seg;
            if (d_tog) ccs_q <= ~ccs_q;
            state_q <= ST_REQ;
          end else if (inc_ovf || b_full) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            status_q <= inc_ovf ? STS_BAD_PTR : STS_TOO_LONG;
            ptr_q    <= sv_ptr_q;
            ccs_q    <= sv_ccs_q;
          end else begin
            ptr_q   <= inc_ptr;
            state_q <= d_chain ? ST_REQ : ST_DRAIN;
          end
        end
        ST_DRAIN: if (b_drained) begin
          state_q  <= ST_IDLE;
          done_q   <= 1'b1;
          status_q <= STS_OK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign deq_ptr_o  = ptr_q;
  assign ccs_o      = ccs_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign status_o   = status_q;
  assign mem_req_o  = (state_q == ST_REQ);
  assign mem_addr_o = ptr_q;
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cyc_wr_i,
  input logic          ccs_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ready_i,
  input logic          td_valid_o,
  input logic          td_ready_i,
  input logic [127:0]  td_data_o,
  input logic [AW-1:0] td_addr_o,
  input logic          td_last_o
);
  assert_fetch_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[3:0] == 4'h0));

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    td_valid_o && !td_ready_i |=> td_valid_o && $stable(td_data_o) && $stable(td_addr_o));

  assert_no_fetch_in_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && td_valid_o));

  assert_single_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    td_valid_o && td_ready_i && td_last_o |=> !td_valid_o);

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_cyc_idle_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !cyc_wr_i |=> $stable(ccs_o));
endmodule

bind trb_ring_consumer trc_checker #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cyc_wr_i   (cyc_wr_i),
  .ccs_o      (ccs_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_ready_i(mem_ready_i),
  .td_valid_o (td_valid_o),
  .td_ready_i (td_ready_i),
  .td_data_o  (td_data_o),
  .td_addr_o  (td_addr_o),
  .td_last_o  (td_last_o)
);

// File: tb/sim_trb_ring_consumer.sv
module sim_trb_ring_consumer;
  localparam int AW = 32;
  localparam int DEPTH = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, ptr_wr = 0, cyc_wr = 0, cyc_wdata = 0;
  logic [AW-1:0] ptr_wdata = '0;
  logic [AW-1:0] deq_ptr, mem_addr, td_addr;
  logic ccs, busy, done, mem_req, td_valid, td_last;
  logic [2:0] status;
  logic mem_ready = 1'b1, mem_rvalid = 1'b0, td_ready = 1'b1;
  logic [127:0] mem_rdata = '0, td_data;

  int checks = 0, errors = 0;
  bit bp = 0;
  logic [127:0] mem [256];
  int cap_n = 0;
  logic [AW-1:0] cap_addr [16];
  logic [31:0] cap_par [16];
  logic cap_last [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  trb_ring_consumer #(.AW(AW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ptr_wr_i(ptr_wr), .ptr_wdata_i(ptr_wdata), .cyc_wr_i(cyc_wr), .cyc_wdata_i(cyc_wdata),
    .deq_ptr_o(deq_ptr), .ccs_o(ccs), .busy_o(busy), .done_o(done), .status_o(status),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .td_valid_o(td_valid), .td_ready_i(td_ready), .td_data_o(td_data),
    .td_addr_o(td_addr), .td_last_o(td_last)
  );

  function automatic logic [127:0] mk_data(logic [31:0] par, logic cyc, logic chain);
    logic [127:0] t = '0;
    t[31:0] = par; t[96] = cyc; t[100] = chain; t[111:106] = 6'd1;
    return t;
  endfunction

  function automatic logic [127:0] mk_link(logic [31:0] seg, logic cyc, logic tog);
    logic [127:0] t = '0;
    t[31:0] = seg; t[96] = cyc; t[97] = tog; t[111:106] = 6'd6;
    return t;
  endfunction

  task automatic put(logic [AW-1:0] a, logic [127:0] t);
    mem[a[11:4]] = t;
  endtask

  // memory responder: request seen at a negedge is accepted at the next edge
  initial begin
    bit pend = 0;
    logic [7:0] pidx = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[pidx];
        pend = 0;
      end else if (mem_req) begin
        pend = 1;
        pidx = mem_addr[11:4];
      end
    end
  end

  // stream sink
  initial begin
    forever begin
      @(negedge clk);
      td_ready = bp ? ~td_ready : 1'b1;
      if (td_valid && td_ready && cap_n < 16) begin
        cap_addr[cap_n] = td_addr;
        cap_par[cap_n]  = td_data[31:0];
        cap_last[cap_n] = td_last;
        cap_n++;
      end
    end
  end

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic set_ring(logic [AW-1:0] p, logic c);
    @(negedge clk);
    ptr_wr = 1; ptr_wdata = p; cyc_wr = 1; cyc_wdata = c;
    @(negedge clk);
    ptr_wr = 0; cyc_wr = 0;
  endtask

  task automatic run_op(bit wr_with_start, logic [AW-1:0] wval, bit wr_busy);
    cap_n = 0;
    @(negedge clk);
    start = 1;
    if (wr_with_start) begin ptr_wr = 1; ptr_wdata = wval; end
    @(negedge clk);
    start = 0; ptr_wr = 0;
    if (wr_busy) begin
      repeat (3) @(negedge clk);
      ptr_wr = 1; ptr_wdata = 32'h0000_ABC0; cyc_wr = 1; cyc_wdata = 1;
      @(negedge clk);
      ptr_wr = 0; cyc_wr = 0; cyc_wdata = 0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "ptr", deq_ptr, 0);
    chk("R1", "ccs", ccs, 0);
    chk("R1", "busy/done/req/valid", {busy, done, mem_req, td_valid}, 0);
  endtask

  task automatic t_basic();
    put(32'h100, mk_data(1, 0, 1)); put(32'h110, mk_data(2, 0, 1));
    put(32'h120, mk_link(32'h200, 0, 0));
    put(32'h200, mk_data(3, 0, 1)); put(32'h210, mk_data(4, 0, 0));
    put(32'h220, mk_link(32'h300, 0, 0));
    put(32'h300, mk_data(5, 0, 1)); put(32'h310, mk_data(6, 0, 0));
    set_ring(32'h100, 0);
    run_op(0, 0, 0);
    chk("R11", "status ok", status, 0);
    chk("R5", "beats", cap_n, 4);
    for (int i = 0; i < 4; i++) chk("R5", "param", cap_par[i], i + 1);
    chk("R6", "addr across link", {cap_addr[0], cap_addr[1], cap_addr[2], cap_addr[3]},
        {32'h100, 32'h110, 32'h200, 32'h210});
    chk("R7", "last flags", {cap_last[0], cap_last[1], cap_last[2], cap_last[3]}, 4'b0001);
    chk("R5", "ptr after", deq_ptr, 32'h220);
    bp = 1;
    run_op(0, 0, 0);
    bp = 0;
    chk("R7", "backpressure beats", cap_n, 2);
    chk("R7", "backpressure data", {cap_par[0], cap_par[1], cap_addr[0], cap_addr[1]},
        {32'd5, 32'd6, 32'h300, 32'h310});
    chk("R7", "backpressure last", {cap_last[0], cap_last[1]}, 2'b01);
    chk("R5", "ptr after second", deq_ptr, 32'h320);
  endtask

  task automatic t_toggle();
    put(32'h400, mk_data(7, 0, 0)); put(32'h410, mk_link(32'h400, 0, 1));
    set_ring(32'h400, 0);
    run_op(0, 0, 0);
    chk("R5", "toggle first td", {cap_n, cap_par[0]}, {32'd1, 32'd7});
    chk("R6", "cycle not flipped before link", {deq_ptr, 31'd0, ccs}, {32'h410, 32'd0});
    run_op(0, 0, 0);
    chk("R4", "empty status", status, 1);
    chk("R4", "nothing emitted", cap_n, 0);
    chk("R6", "link kept on empty", {deq_ptr, 31'd0, ccs}, {32'h400, 32'd1});
    put(32'h400, mk_data(8, 1, 0));
    run_op(0, 0, 0);
    chk("R6", "after flip", {cap_n, cap_par[0], 31'd0, ccs}, {32'd1, 32'd8, 32'd1});
  endtask

  task automatic t_incomplete();
    put(32'h500, mk_data(9, 0, 1)); put(32'h510, mk_link(32'h600, 0, 1));
    put(32'h600, mk_data(10, 0, 0));
    set_ring(32'h500, 0);
    run_op(0, 0, 0);
    chk("R8", "status", status, 2);
    chk("R8", "nothing emitted", cap_n, 0);
    chk("R8", "restored", {deq_ptr, 31'd0, ccs}, {32'h500, 32'd0});
  endtask

  task automatic t_depth();
    for (int i = 0; i < 9; i++) put(32'h700 + 16 * i, mk_data(20 + i, 0, i != 8));
    set_ring(32'h700, 0);
    run_op(0, 0, 0);
    chk("R9", "too long status", status, 4);
    chk("R9", "too long no beats", cap_n, 0);
    chk("R9", "too long restored", deq_ptr, 32'h700);
  endtask

  task automatic t_bad_ptr();
    put(32'hFFFF_FFF0, mk_data(33, 0, 0));
    set_ring(32'hFFFF_FFF0, 0);
    run_op(0, 0, 0);
    chk("R10", "status", status, 3);
    chk("R10", "no beats", cap_n, 0);
    chk("R10", "ptr kept", deq_ptr, 32'hFFFF_FFF0);
  endtask

  task automatic t_ctrl();
    for (int i = 0; i < 8; i++) put(32'h800 + 16 * i, mk_data(40 + i, 0, i != 7));
    set_ring(32'h100, 0);
    run_op(1, 32'h0000_0807, 1);
    chk("R9", "exact depth status", status, 0);
    chk("R9", "exact depth beats", cap_n, 8);
    chk("R2", "start+write first addr", cap_addr[0], 32'h800);
    chk("R9", "exact depth last", {cap_last[6], cap_last[7], cap_par[7]}, {2'b01, 32'd47});
    chk("R2", "busy write ignored", {deq_ptr, 31'd0, ccs}, {32'h880, 32'd0});
    @(negedge clk);
    chk("R11", "done single cycle", {busy, done}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_toggle();
    t_incomplete();
    t_depth();
    t_bad_ptr();
    t_ctrl();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule